// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps a free-running time-of-day value in nanoseconds for precision time protocol timestamping. Every enabled tick of the datapath clock adds a programmable fixed-point increment to a 96-bit accumulator. The accumulator holds 64 integer nanosecond bits above 32 fractional bits, so the count stays in nanoseconds when the tick period changes with link speed. The 64-bit nanosecond count is wide enough that wrap-around is not a design concern.

A 32-bit strobe-driven register port gives software access to the time and to the increment. A read of the low time word captures the upper word, so that a later read of the high word returns a coherent pair. Writes go low word first, and the full 64-bit value takes effect only when the high word is written. The increment reloads a default for the current link speed whenever the speed code changes. The slowest, unsupported speed loads a zero increment, which freezes the clock.

Top module: `tod_ns_counter`

## Requirements
- R1: After reset the time is 0, the fraction is 0, the read data is 0 and the increment is 0x1_99999999.
- R2: On each clock edge with `tsync_en_i` high and no time commit, the 96-bit value {time, fraction} grows by the 64-bit increment, which has 32 fractional bits. Carries pass from the fraction into the time and from the low time word into the high one.
- R3: With `tsync_en_i` low and no time commit, `time_o` does not change.
- R4: A write to address 0 (time low) only stages the word and leaves `time_o` unchanged. A write to address 1 (time high) loads time = {written word, staged low word} and clears the fraction.
- R5: A time commit wins over the increment add in the same edge. `time_o` then equals the written value exactly, and the next enabled tick adds the increment to a zero fraction.
- R6: A read of address 0 returns time bits 31:0 and captures time bits 63:32. A read of address 1 returns the captured word, even if the time has since changed.
- R7: A write to address 2 (increment low) only stages the word. A write to address 3 (increment high) sets increment = {written word, staged low word}. Reads of addresses 2 and 3 return the increment in use, low and high word.
- R8: When `speed_i` changes, the increment loads the default for the new code one edge later: 0 (fastest or no link) 0x1_99999999, 1 (middle) 0x3_33333333, 2 (lowest) 0x20_00000000. An increment-high write in that same edge wins.
- R9: Speed code 3 loads a zero increment, and the time then stays fixed while enabled.
- R10: `reg_rdata_o` updates one edge after a read strobe and holds its value on cycles without a read, including cycles with writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Datapath clock, one tick per edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tsync_en_i | input | 1 | Enables counting |
| speed_i | input | 2 | Link speed code (0 fastest/no link, 1 middle, 2 lowest, 3 unsupported) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | 0 time low, 1 time high, 2 increment low, 3 increment high |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| time_o | output | 64 | Integer nanosecond time |

## Verification
The accumulator runs with three increments. The 3.2 ns value leaves a non-zero fraction, which shows whether the fraction carries. The 32 ns value adds whole nanoseconds, which shows that an existing fraction is kept. The 1.6 ns value follows on top of both. A start just below a 32-bit boundary shows whether the carry reaches the high word. A time commit while counting tells priority apart from a late or doubled add. Writing new time between a low read and a high read tells a real capture apart from a live read. A zero increment and a low enable each freeze the clock, and the bench checks them separately.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int REG_W  = 32;
  localparam int FRAC_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    SPD_FAST = 2'd0,
    SPD_MID  = 2'd1,
    SPD_LOW  = 2'd2,
    SPD_STOP = 2'd3
  } speed_e;

  typedef enum logic [ADDR_W-1:0] {
    A_TIME_LO = 2'd0,
    A_TIME_HI = 2'd1,
    A_INC_LO  = 2'd2,
    A_INC_HI  = 2'd3
  } reg_addr_e;

  // Per-tick increment, 32 fractional bits.
  function automatic logic [2*REG_W-1:0] speed_inc(logic [1:0] spd);
    logic [2*REG_W-1:0] v;
    case (speed_e'(spd))
      SPD_FAST: v = 64'h0000_0001_9999_9999;
      SPD_MID:  v = 64'h0000_0003_3333_3333;
      SPD_LOW:  v = 64'h0000_0020_0000_0000;
      default:  v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/tod_half_stage.sv
`timescale 1ns/1ps
module tod_half_stage #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lo_wr_i,
  input  logic         hi_wr_i,
  input  logic [W-1:0] data_i,
  output logic         commit_o,
  output logic [2*W-1:0] full_o
);
  logic [W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lo_q <= '0;
    else if (lo_wr_i) lo_q <= data_i;
  end

  assign commit_o = hi_wr_i;
  assign full_o   = {data_i, lo_q};
endmodule

// File: rtl/tod_inc_reg.sv
`timescale 1ns/1ps
module tod_inc_reg
  import tod_pkg::*;
#(
  parameter int INC_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       speed_i,
  input  logic             commit_i,
  input  logic [INC_W-1:0] commit_val_i,
  output logic [1:0]       spd_prev_o,
  output logic [INC_W-1:0] inc_o
);
  logic [1:0]       spd_q;
  logic [INC_W-1:0] inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spd_q <= SPD_FAST;
      inc_q <= INC_W'(speed_inc(SPD_FAST));
    end else begin
      spd_q <= speed_i;
      if (commit_i)              inc_q <= commit_val_i;
      else if (speed_i != spd_q) inc_q <= INC_W'(speed_inc(speed_i));
    end
  end

  assign spd_prev_o = spd_q;
  assign inc_o      = inc_q;
endmodule

// File: rtl/tod_accum.sv
`timescale 1ns/1ps
module tod_accum #(
  parameter int TIME_W = 64,
  parameter int FRAC_W = 32,
  parameter int INC_W  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [INC_W-1:0]  inc_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_val_i,
  output logic [TIME_W-1:0] time_o
);
  localparam int ACC_W = TIME_W + FRAC_W;

  logic [ACC_W-1:0] acc_q, acc_add;

  assign acc_add = acc_q + {{(ACC_W-INC_W){1'b0}}, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= {load_val_i, {FRAC_W{1'b0}}};
    else if (en_i)   acc_q <= acc_add;
  end

  assign time_o = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/tod_ns_counter.sv
`timescale 1ns/1ps
module tod_ns_counter
  import tod_pkg::*;
#(
  parameter int RW = tod_pkg::REG_W,
  parameter int FW = tod_pkg::FRAC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tsync_en_i,
  input  logic [1:0]    speed_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [RW-1:0] reg_wdata_i,
  output logic [RW-1:0] reg_rdata_o,
  output logic [2*RW-1:0] time_o
);
  localparam int TW = 2 * RW;

  logic          t_commit, i_commit;
  logic [TW-1:0] t_full, i_full, inc_w;
  logic [1:0]    spd_prev;
  logic [RW-1:0] snap_q, rdata_q;

  tod_half_stage #(.W(RW)) u_time_stage (
    .clk_i, .rst_ni,
    .lo_wr_i (reg_wr_i && reg_addr_i == A_TIME_LO),
    .hi_wr_i (reg_wr_i && reg_addr_i == A_TIME_HI),
    .data_i  (reg_wdata_i),
    .commit_o(t_commit),
    .full_o  (t_full)
  );

  tod_half_stage #(.W(RW)) u_inc_stage (
    .clk_i, .rst_ni,
    .lo_wr_i (reg_wr_i && reg_addr_i == A_INC_LO),
    .hi_wr_i (reg_wr_i && reg_addr_i == A_INC_HI),
    .data_i  (reg_wdata_i),
    .commit_o(i_commit),
    .full_o  (i_full)
  );

  tod_inc_reg #(.INC_W(TW)) u_inc (
    .clk_i, .rst_ni,
    .speed_i,
    .commit_i    (i_commit),
    .commit_val_i(i_full),
    .spd_prev_o  (spd_prev),
    .inc_o       (inc_w)
  );

  tod_accum #(.TIME_W(TW), .FRAC_W(FW), .INC_W(TW)) u_acc (
    .clk_i, .rst_ni,
    .en_i      (tsync_en_i),
    .inc_i     (inc_w),
    .load_i    (t_commit),
    .load_val_i(t_full),
    .time_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      snap_q  <= '0;
    end else if (reg_rd_i) begin
      case (reg_addr_e'(reg_addr_i))
        A_TIME_LO: begin
          rdata_q <= time_o[RW-1:0];
          snap_q  <= time_o[TW-1:RW];
        end
        A_TIME_HI: rdata_q <= snap_q;
        A_INC_LO:  rdata_q <= inc_w[RW-1:0];
        default:   rdata_q <= inc_w[TW-1:RW];
      endcase
    end
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/tod_ns_counter_chk.sv
`timescale 1ns/1ps
module tod_ns_counter_chk
  import tod_pkg::*;
#(
  parameter int RW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tsync_en_i,
  input logic [1:0]    speed_i,
  input logic          reg_wr_i,
  input logic          reg_rd_i,
  input logic [1:0]    reg_addr_i,
  input logic [RW-1:0] reg_wdata_i,
  input logic [RW-1:0] reg_rdata_o,
  input logic [2*RW-1:0] time_o,
  input logic [2*RW-1:0] inc_w,
  input logic [1:0]    spd_prev
);
  logic t_hi_wr, i_hi_wr;
  assign t_hi_wr = reg_wr_i && reg_addr_i == A_TIME_HI;
  assign i_hi_wr = reg_wr_i && reg_addr_i == A_INC_HI;

  a_r3_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tsync_en_i && !t_hi_wr) |=> $stable(time_o));

  a_r4_hi_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_hi_wr |=> time_o[2*RW-1:RW] == $past(reg_wdata_i));

  a_r2_no_backstep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsync_en_i && !t_hi_wr) |=> time_o >= $past(time_o));

  a_r9_zero_inc_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_w == '0 && !t_hi_wr) |=> $stable(time_o));

  a_r6_lo_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == A_TIME_LO) |=> reg_rdata_o == $past(time_o[RW-1:0]));

  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> $stable(reg_rdata_o));

  a_r8_speed_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_i != spd_prev && !i_hi_wr) |=> inc_w == speed_inc($past(speed_i)));
endmodule

bind tod_ns_counter tod_ns_counter_chk #(.RW(RW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tsync_en_i(tsync_en_i), .speed_i(speed_i),
  .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .time_o(time_o),
  .inc_w(inc_w), .spd_prev(spd_prev)
);

// File: tb/tod_ns_counter_tb.sv
`timescale 1ns/1ps
module tod_ns_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  speed = 2'd0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] tm;

  int n_run = 0, n_fail = 0;
  logic [95:0] m_acc;
  logic [63:0] m_inc;

  always #2.5 clk = ~clk;

  tod_ns_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tsync_en_i(en), .speed_i(speed),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .time_o(tm)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic set_speed(logic [1:0] s);
    @(negedge clk); speed = s;
    @(negedge clk);
  endtask

  task automatic set_time(logic [63:0] v);
    reg_write(2'd0, v[31:0]);
    reg_write(2'd1, v[63:32]);
    m_acc = {v, 32'h0};
  endtask

  task automatic run_ticks(int n);
    @(negedge clk); en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      m_acc = m_acc + {32'h0, m_inc};
    end
    en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 time", tm, 64'h0);
    chk("R1 rdata", {32'h0, rdata}, 64'h0);
    reg_read(2'd2, d); chk("R1 inc lo", {32'h0, d}, 64'h9999_9999);
    reg_read(2'd3, d); chk("R1 inc hi", {32'h0, d}, 64'h1);
  endtask

  task automatic t_speed_defaults();
    logic [31:0] lo, hi;
    set_speed(2'd1);
    reg_read(2'd2, lo); reg_read(2'd3, hi);
    chk("R8 mid", {hi, lo}, 64'h3_3333_3333);
    set_speed(2'd2);
    reg_read(2'd2, lo); reg_read(2'd3, hi);
    chk("R8 low", {hi, lo}, 64'h20_0000_0000);
    set_speed(2'd0);
    reg_read(2'd2, lo); reg_read(2'd3, hi);
    chk("R8 fast", {hi, lo}, 64'h1_9999_9999);
  endtask

  task automatic t_inc_write();
    logic [31:0] lo, hi;
    reg_write(2'd2, 32'hAAAA_0000);
    reg_read(2'd2, lo);
    chk("R7 lo staged only", {32'h0, lo}, 64'h9999_9999);
    reg_write(2'd3, 32'h5);
    reg_read(2'd2, lo); reg_read(2'd3, hi);
    chk("R7 commit", {hi, lo}, 64'h5_AAAA_0000);
    set_speed(2'd1);
  endtask

  task automatic t_time_write();
    set_time(64'h0);
    reg_write(2'd0, 32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    chk("R4 lo alone", tm, 64'h0);
    reg_write(2'd1, 32'h0000_0042);
    chk("R4 hi commit", tm, 64'h42_DEAD_BEEF);
  endtask

  task automatic t_disable();
    set_time(64'h77);
    repeat (5) @(negedge clk);
    chk("R3 disabled hold", tm, 64'h77);
  endtask

  task automatic t_accumulate();
    set_speed(2'd1); m_inc = 64'h3_3333_3333;
    set_time(64'h1_FFFF_FFF0);
    run_ticks(7);
    chk("R2 mid ticks carry", tm, m_acc[95:32]);
    set_speed(2'd2); m_inc = 64'h20_0000_0000;
    run_ticks(3);
    chk("R2 low ticks keep fraction", tm, m_acc[95:32]);
    set_speed(2'd0); m_inc = 64'h1_9999_9999;
    run_ticks(5);
    chk("R2 fast ticks", tm, m_acc[95:32]);
  endtask

  task automatic t_commit_priority();
    set_speed(2'd1);
    set_time(64'h1000);
    run_ticks(1);
    reg_write(2'd0, 32'h0000_0500);
    @(negedge clk); en = 1'b1; wr = 1'b1; addr = 2'd1; wdata = 32'h0;
    @(negedge clk); wr = 1'b0;
    chk("R5 exact load", tm, 64'h500);
    @(negedge clk); en = 1'b0;
    chk("R5 fraction cleared", tm, 64'h503);
  endtask

  task automatic t_zero_stop();
    logic [31:0] lo, hi;
    set_speed(2'd3);
    reg_read(2'd2, lo); reg_read(2'd3, hi);
    chk("R9 zero inc", {hi, lo}, 64'h0);
    set_time(64'h1234);
    m_inc = 64'h0;
    run_ticks(10);
    chk("R9 stopped", tm, 64'h1234);
  endtask

  task automatic t_read_latch();
    logic [31:0] d;
    set_time(64'h1234_5678_9ABC_DEF0);
    reg_read(2'd0, d); chk("R6 lo", {32'h0, d}, 64'h9ABC_DEF0);
    set_time(64'h0BAD_0000_0000_1111);
    reg_read(2'd1, d); chk("R6 hi latched", {32'h0, d}, 64'h1234_5678);
    reg_read(2'd0, d); chk("R6 lo new", {32'h0, d}, 64'h1111);
    reg_read(2'd1, d); chk("R6 hi new", {32'h0, d}, 64'h0BAD_0000);
  endtask

  task automatic t_rdata_hold();
    logic [31:0] d;
    reg_read(2'd0, d);
    reg_write(2'd2, 32'hFFFF_FFFF);
    set_time(64'h9);
    repeat (3) @(negedge clk);
    chk("R10 hold", {32'h0, rdata}, {32'h0, d});
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_acc = '0; m_inc = 64'h1_9999_9999;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_speed_defaults();
    t_inc_write();
    t_time_write();
    t_disable();
    t_accumulate();
    t_commit_priority();
    t_read_latch();
    t_zero_stop();
    t_rdata_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule